// File: doc/BRIEF.md
# Reconfigurable cache/scratchpad instruction memory

This block is an instruction-fetch store built from four equal banks. Each bank holds a 256-byte data array and a tag array. A per-bank mode bit chooses its role. With the bit at 0 the bank is one way of a four-way set-associative instruction cache. With the bit at 1 the bank joins a contiguous scratchpad window, and its tag array is never powered for lookups.

A fetch whose address falls inside the programmed window is served from exactly one data bank, and no tag array is enabled for it. Any other fetch enables only the tag and data arrays of the banks still in cache mode. A miss pulls a 16-byte line from next-level memory and places it in a round-robin victim. Scratchpad contents arrive through a separate load write port. Software changes the bank roles and the window at runtime through one configuration write.

The per-bank read enables are brought out as ports. They are the gating signals that the energy saving depends on, and they can be observed directly.

Top module: `recfg_imem`

## Requirements
- R1: After reset, all four banks are in cache mode and no scratchpad window exists. fetch_ready is 1. rsp_valid, mem_req, rd_tag_en and rd_data_en are all 0.
- R2: A configuration write is accepted in either of two cases. In the first, the new mode has no scratchpad banks. In the second, cfg_lo <= cfg_hi and cfg_hi - cfg_lo + 1 is at most 256 times the number of mode bits set to 1. In every other case the whole write is ignored, and the mode bits and bounds keep their previous values.
- R3: rd_tag_en is never 1 for a bank whose mode bit is 1. For a fetch that hits the scratchpad window, all four tag enables are 0 and rd_data_en is one-hot.
- R4: A fetch address A hits the scratchpad when at least one bank is in scratchpad mode and cfg_lo <= A <= cfg_hi, with both bounds inclusive. Let off = A - cfg_lo. Bits off[9:8] give a slice number k, which selects the k-th scratchpad bank counted in ascending bank index. Bits off[7:2] select the 32-bit word inside that bank.
- R5: A fetch outside the window drives rd_tag_en and rd_data_en, in its accept cycle, to the set of banks whose mode bit is 0. Bit i of each enable belongs to bank i.
- R6: A scratchpad load (spm_wr_en) to an address inside the window writes spm_wr_data to the location defined by R4. A load outside the window changes nothing.
- R7: A fetch is accepted when fetch_req and fetch_ready are both 1. On a scratchpad or cache hit, rsp_valid is 1 with the word in the next cycle, and fetch_ready is 0 in that cycle.
- R8: Cache lines are 16 bytes. The set is addr[7:4], the word in the line is addr[3:2] and the tag is addr[15:8]. On a miss, mem_req is a one-cycle pulse two cycles after the accept cycle, with mem_addr set to the line-aligned address. Memory then returns four mem_rvalid beats in ascending word order. rsp_valid comes in the cycle after the last beat and carries the requested word.
- R9: After a line has been refilled, a fetch of any word of that line hits until the line is evicted.
- R10: The miss victim is chosen round-robin among the cache-mode banks. The first victim after reset is bank 0. After each allocation the search starts at the bank after the victim.
- R11: With no bank in cache mode, a fetch outside the window still refills from memory and returns the word, but nothing is allocated. A repeat fetch of that address misses again.
- R12: When a bank moves from scratchpad mode to cache mode, all its valid bits are cleared. Data written to it as scratchpad is never returned as a cache hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 4 | New mode bits, 1 = scratchpad |
| cfg_lo | input | 16 | New lower window bound (inclusive) |
| cfg_hi | input | 16 | New upper window bound (inclusive) |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 16 | Fetch byte address (word aligned) |
| fetch_ready | output | 1 | Block can accept a fetch |
| rsp_valid | output | 1 | Fetch response strobe |
| rsp_data | output | 32 | Fetched instruction word |
| spm_wr_en | input | 1 | Scratchpad load strobe |
| spm_wr_addr | input | 16 | Scratchpad load byte address |
| spm_wr_data | input | 32 | Scratchpad load word |
| mem_req | output | 1 | Line request to next-level memory |
| mem_addr | output | 16 | Line-aligned request address |
| mem_rvalid | input | 1 | Refill beat valid |
| mem_rdata | input | 32 | Refill beat word |
| rd_tag_en | output | 4 | Per-bank tag array read enable |
| rd_data_en | output | 4 | Per-bank data array read enable |

## Verification
The bank enables are combinational in the accept cycle, so the bench samples them just after it raises fetch_req. A hit answers one cycle after acceptance. A miss raises mem_req at two cycles, and its answer follows five cycles after the request when memory returns beats back to back after a one-cycle gap. The bench samples each result at the falling edge of exactly that cycle, never by polling. Each expected word is derived from the address pattern of the memory model or from the value the bench loaded into the window.

// File: rtl/recfg_imem_pkg.sv
package recfg_imem_pkg;
  localparam int NB         = 4;
  localparam int BANK_BYTES = 256;
  localparam int LINE_BYTES = 16;
  localparam int WORD_BYTES = 4;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 32;

  localparam int BANK_W     = $clog2(NB);
  localparam int WPB        = BANK_BYTES / WORD_BYTES;
  localparam int WIDX_W     = $clog2(WPB);
  localparam int SETS       = BANK_BYTES / LINE_BYTES;
  localparam int SET_W      = $clog2(SETS);
  localparam int LINE_WORDS = LINE_BYTES / WORD_BYTES;
  localparam int LW_W       = $clog2(LINE_WORDS);
  localparam int BOFF_W     = $clog2(BANK_BYTES);
  localparam int LOFF_W     = $clog2(LINE_BYTES);
  localparam int WOFF_W     = $clog2(WORD_BYTES);
  localparam int TAG_W      = ADDR_W - BOFF_W;

  typedef logic [NB-1:0]     bmask_t;
  typedef logic [BANK_W-1:0] bidx_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [2:0] {ST_IDLE, ST_LOOK, ST_REQ, ST_FILL, ST_DONE} fsm_t;

  // number of banks set in a mask
  function automatic int unsigned ones(bmask_t m);
    int unsigned n = 0;
    for (int i = 0; i < NB; i++) n += 32'(m[i]);
    return n;
  endfunction

  // index of the n-th set bit, counted from bank 0 upward
  function automatic bidx_t nth_bank(bmask_t m, bidx_t n);
    bidx_t       r    = '0;
    int unsigned seen = 0;
    for (int i = 0; i < NB; i++) begin
      if (m[i]) begin
        if (seen == 32'(n)) r = bidx_t'(i);
        seen++;
      end
    end
    return r;
  endfunction

  // first set bank at or after pointer p, wrapping
  function automatic bidx_t rr_pick(bmask_t m, bidx_t p);
    bidx_t r     = p;
    logic  found = 1'b0;
    for (int k = 0; k < NB; k++) begin
      bidx_t c = p + bidx_t'(k);
      if (!found && m[c]) begin
        r     = c;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  // window must fit in the banks given to the scratchpad
  function automatic logic bounds_ok(bmask_t mode, addr_t lo, addr_t hi);
    int unsigned n = ones(mode);
    if (n == 0) return 1'b1;
    if (lo > hi) return 1'b0;
    return (32'(hi) - 32'(lo)) < (n * BANK_BYTES);
  endfunction

  function automatic addr_t line_base(addr_t a);
    return a & ~addr_t'(LINE_BYTES - 1);
  endfunction
endpackage

// File: rtl/imem_spm_map.sv
module imem_spm_map
  import recfg_imem_pkg::*;
(
  input  bmask_t            mode,
  input  addr_t             lo,
  input  addr_t             hi,
  input  addr_t             addr,
  output logic              hit,
  output bidx_t             bank,
  output logic [WIDX_W-1:0] widx
);
  addr_t                      off;
  logic [ADDR_W-BOFF_W-1:0]   slice;
  int unsigned                nspm;

  always_comb begin
    off   = addr - lo;
    slice = off[ADDR_W-1:BOFF_W];
    nspm  = ones(mode);
    hit   = (nspm != 0) && (addr >= lo) && (addr <= hi) && (32'(slice) < nspm);
    bank  = nth_bank(mode, bidx_t'(slice));
    widx  = off[BOFF_W-1:WOFF_W];
  end

  // a window hit must land on a bank that is in scratchpad mode
  always_comb begin
    if (hit) AST_SPM_BANK_IN_MODE: assert (mode[bank]) else $error("window hit on cache bank"); // R4
  end
endmodule

// File: rtl/imem_bank.sv
module imem_bank
  import recfg_imem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_valid,
  input  logic              d_rd_en,
  input  logic [WIDX_W-1:0] d_rd_idx,
  output word_t             d_rd_q,
  input  logic              d_wr_en,
  input  logic [WIDX_W-1:0] d_wr_idx,
  input  word_t             d_wr_data,
  input  logic              t_rd_en,
  input  logic [SET_W-1:0]  t_rd_set,
  output logic [TAG_W-1:0]  t_rd_tag,
  output logic              t_rd_vld,
  input  logic              t_wr_en,
  input  logic [SET_W-1:0]  t_wr_set,
  input  logic [TAG_W-1:0]  t_wr_tag
);
  word_t            data_arr [WPB];
  logic [TAG_W-1:0] tag_arr  [SETS];
  logic [SETS-1:0]  vld;

  always_ff @(posedge clk) begin
    if (d_wr_en) data_arr[d_wr_idx] <= d_wr_data;
    if (d_rd_en) d_rd_q <= data_arr[d_rd_idx];
    if (t_wr_en) tag_arr[t_wr_set] <= t_wr_tag;
    if (t_rd_en) t_rd_tag <= tag_arr[t_rd_set];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld      <= '0;
      t_rd_vld <= 1'b0;
    end else begin
      if (clr_valid)    vld           <= '0;
      else if (t_wr_en) vld[t_wr_set] <= 1'b1;
      if (t_rd_en) t_rd_vld <= vld[t_rd_set];
    end
  end

  AST_CLEAR_EMPTIES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> (vld == '0)) else $error("valid bits survive mode change"); // R12
endmodule

// File: rtl/imem_victim.sv
module imem_victim
  import recfg_imem_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  bmask_t mask,
  input  logic   take,
  output bidx_t  pick
);
  bidx_t ptr_q;

  assign pick = rr_pick(mask, ptr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (take) ptr_q <= pick + bidx_t'(1);
  end

  AST_VICTIM_IS_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> mask[pick]) else $error("victim not in cache mode"); // R10
endmodule

// File: rtl/recfg_imem.sv
module recfg_imem
  import recfg_imem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [NB-1:0]     cfg_mode,
  input  logic [ADDR_W-1:0] cfg_lo,
  input  logic [ADDR_W-1:0] cfg_hi,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              spm_wr_en,
  input  logic [ADDR_W-1:0] spm_wr_addr,
  input  logic [DATA_W-1:0] spm_wr_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [NB-1:0]     rd_tag_en,
  output logic [NB-1:0]     rd_data_en
);
  // configuration state
  bmask_t mode_q;
  addr_t  lo_q, hi_q;
  logic   cfg_take;

  assign cfg_take = cfg_we && bounds_ok(cfg_mode, cfg_lo, cfg_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (cfg_take) begin
      mode_q <= cfg_mode;
      lo_q   <= cfg_lo;
      hi_q   <= cfg_hi;
    end
  end

  // mode, bounds and window always agree
  AST_BOUNDS_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    bounds_ok(mode_q, lo_q, hi_q)) else $error("window larger than its banks"); // R2

  // window decode for fetch and for scratchpad load
  logic              f_hit, l_hit;
  bidx_t             f_bank, l_bank;
  logic [WIDX_W-1:0] f_widx, l_widx;

  imem_spm_map u_fmap (.mode(mode_q), .lo(lo_q), .hi(hi_q), .addr(fetch_addr),
                       .hit(f_hit), .bank(f_bank), .widx(f_widx));
  imem_spm_map u_lmap (.mode(mode_q), .lo(lo_q), .hi(hi_q), .addr(spm_wr_addr),
                       .hit(l_hit), .bank(l_bank), .widx(l_widx));

  // fetch control
  fsm_t              st_q;
  addr_t             addr_q;
  logic              spm_q;
  bidx_t             sbank_q;
  bmask_t            cmask_q;
  bidx_t             vict_q;
  logic              alloc_q;
  logic [LW_W-1:0]   beat_q;
  word_t             cap_q;
  logic              accept;
  logic              hit_any;
  logic              last_beat;
  bmask_t            hit_vec;
  bmask_t            t_vld;
  word_t             d_q   [NB];
  logic [TAG_W-1:0]  t_tag [NB];
  logic [SET_W-1:0]  set_q;
  logic [TAG_W-1:0]  tagv_q;
  logic [LW_W-1:0]   wsel_q;
  bidx_t             pick;
  logic              take;

  assign accept    = (st_q == ST_IDLE) && fetch_req;
  assign set_q     = addr_q[BOFF_W-1:LOFF_W];
  assign tagv_q    = addr_q[ADDR_W-1:BOFF_W];
  assign wsel_q    = addr_q[LOFF_W-1:WOFF_W];
  assign hit_any   = spm_q || (|hit_vec);
  assign last_beat = mem_rvalid && (beat_q == LW_W'(LINE_WORDS - 1));
  assign take      = (st_q == ST_LOOK) && !hit_any && (|cmask_q);

  // bank enable gating for the accept cycle
  always_comb begin
    rd_tag_en  = '0;
    rd_data_en = '0;
    if (accept) begin
      if (f_hit) begin
        rd_data_en[f_bank] = 1'b1;
      end else begin
        rd_tag_en  = ~mode_q;
        rd_data_en = ~mode_q;
      end
    end
  end

  // a bank read as scratchpad forbids every tag read and any second data read
  AST_SPM_GATES_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data_en & mode_q) != '0) |-> (rd_tag_en == '0) && $onehot(rd_data_en))
    else $error("tag arrays enabled on window fetch"); // R3

  imem_victim u_vict (.clk(clk), .rst_n(rst_n), .mask(cmask_q), .take(take), .pick(pick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      spm_q   <= 1'b0;
      sbank_q <= '0;
      cmask_q <= '0;
      vict_q  <= '0;
      alloc_q <= 1'b0;
      beat_q  <= '0;
      cap_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_LOOK;
          addr_q  <= fetch_addr;
          spm_q   <= f_hit;
          sbank_q <= f_bank;
          cmask_q <= ~mode_q;
        end
        ST_LOOK: begin
          if (hit_any) st_q <= ST_IDLE;
          else begin
            st_q    <= ST_REQ;
            vict_q  <= pick;
            alloc_q <= |cmask_q;
          end
        end
        ST_REQ: begin
          st_q   <= ST_FILL;
          beat_q <= '0;
        end
        ST_FILL: if (mem_rvalid) begin
          if (beat_q == wsel_q) cap_q <= mem_rdata;
          beat_q <= beat_q + LW_W'(1);
          if (last_beat) st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign fetch_ready = (st_q == ST_IDLE);
  assign mem_req     = (st_q == ST_REQ);
  assign mem_addr    = line_base(addr_q);
  assign rsp_valid   = ((st_q == ST_LOOK) && hit_any) || (st_q == ST_DONE);

  always_comb begin
    rsp_data = cap_q;
    if (st_q == ST_LOOK) begin
      rsp_data = '0;
      if (spm_q) rsp_data = d_q[sbank_q];
      else begin
        for (int b = 0; b < NB; b++) if (hit_vec[b]) rsp_data = rsp_data | d_q[b];
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req) else $error("line request longer than one cycle"); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ready) |=> !fetch_ready) else $error("ready during lookup"); // R7
  AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !fetch_ready) else $error("response while idle"); // R7
  AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOOK) |-> $onehot0(hit_vec)) else $error("line held in two ways"); // R9

  // per-bank arrays and their write steering
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic              fill_wr, ld_wr, wr_en, clr;
    logic [WIDX_W-1:0] wr_idx;
    word_t             wr_data;

    assign fill_wr = (st_q == ST_FILL) && mem_rvalid && alloc_q &&
                     (vict_q == bidx_t'(b)) && !mode_q[b];
    assign ld_wr   = spm_wr_en && l_hit && (l_bank == bidx_t'(b));
    assign wr_en   = fill_wr || ld_wr;
    assign wr_idx  = fill_wr ? {set_q, beat_q} : l_widx;
    assign wr_data = fill_wr ? mem_rdata : spm_wr_data;
    assign clr     = cfg_take && mode_q[b] && !cfg_mode[b];

    imem_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_valid(clr),
      .d_rd_en  (rd_data_en[b]),
      .d_rd_idx (f_hit ? f_widx : fetch_addr[BOFF_W-1:WOFF_W]),
      .d_rd_q   (d_q[b]),
      .d_wr_en  (wr_en),
      .d_wr_idx (wr_idx),
      .d_wr_data(wr_data),
      .t_rd_en  (rd_tag_en[b]),
      .t_rd_set (fetch_addr[BOFF_W-1:LOFF_W]),
      .t_rd_tag (t_tag[b]),
      .t_rd_vld (t_vld[b]),
      .t_wr_en  (fill_wr && last_beat),
      .t_wr_set (set_q),
      .t_wr_tag (tagv_q)
    );

    assign hit_vec[b] = cmask_q[b] && t_vld[b] && (t_tag[b] == tagv_q);
  end
endmodule

// File: tb/recfg_imem_tb_top.sv
module recfg_imem_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_mode = '0;
  logic [15:0] cfg_lo = '0, cfg_hi = '0;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        fetch_ready, rsp_valid, mem_req;
  logic [31:0] rsp_data;
  logic        spm_wr_en = 1'b0;
  logic [15:0] spm_wr_addr = '0;
  logic [31:0] spm_wr_data = '0;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  rd_tag_en, rd_data_en;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  recfg_imem dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_lo(cfg_lo),
    .cfg_hi(cfg_hi), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .spm_wr_en(spm_wr_en), .spm_wr_addr(spm_wr_addr), .spm_wr_data(spm_wr_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rd_tag_en(rd_tag_en), .rd_data_en(rd_data_en)
  );

  // next-level memory contents: a pattern of the word address
  function automatic logic [31:0] memw(input logic [15:0] a);
    return {a ^ 16'hC0DE, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: gap of one cycle after the request, then four beats
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [15:0] base;
        base = mem_addr;
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          mem_rvalid = 1'b1;
          mem_rdata  = memw(base + 16'(4 * k));
        end
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic do_cfg(input logic [3:0] m, input logic [15:0] lo, input logic [15:0] hi);
    cfg_we = 1'b1; cfg_mode = m; cfg_lo = lo; cfg_hi = hi;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] a, input logic [31:0] d);
    spm_wr_en = 1'b1; spm_wr_addr = a; spm_wr_data = d;
    @(negedge clk);
    spm_wr_en = 1'b0;
  endtask

  // starts and ends at a falling edge with the block idle
  task automatic do_fetch(input logic [15:0] a, input logic miss, input logic [31:0] exp_d,
                          input logic [3:0] exp_te, input logic [3:0] exp_de, input string req);
    check({req, " ready"}, 32'(fetch_ready), 32'd1);
    fetch_req = 1'b1; fetch_addr = a;
    #1;
    check({req, " tag enables"}, 32'(rd_tag_en), 32'(exp_te));
    check({req, " data enables"}, 32'(rd_data_en), 32'(exp_de));
    @(negedge clk);
    fetch_req = 1'b0;
    check({req, " R7 busy"}, 32'(fetch_ready), 32'd0);
    if (!miss) begin
      check({req, " R7 hit valid"}, 32'(rsp_valid), 32'd1);
      check({req, " R7 hit data"}, rsp_data, exp_d);
    end else begin
      check({req, " R8 no early rsp"}, 32'(rsp_valid), 32'd0);
      @(negedge clk);
      check({req, " R8 mem_req"}, 32'(mem_req), 32'd1);
      check({req, " R8 mem_addr"}, 32'(mem_addr), 32'(a & 16'hFFF0));
      repeat (5) @(negedge clk);
      check({req, " R8 miss valid"}, 32'(rsp_valid), 32'd1);
      check({req, " R8 miss data"}, rsp_data, exp_d);
    end
    @(negedge clk);
  endtask

  // cache walk in mode 0000: address, 1 = miss
  localparam logic [16:0] VEC [14] = '{
    {16'h0044, 1'b0}, {16'h1040, 1'b1}, {16'h2040, 1'b1}, {16'h3040, 1'b1},
    {16'h0048, 1'b0}, {16'h1048, 1'b0}, {16'h204C, 1'b0}, {16'h3040, 1'b0},
    {16'h4040, 1'b1}, {16'h0040, 1'b1}, {16'h1040, 1'b1}, {16'h4044, 1'b0},
    {16'h0100, 1'b1}, {16'h0104, 1'b0}
  };

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", 32'(fetch_ready), 32'd1);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 mem_req", 32'(mem_req), 32'd0);
    check("R1 tag enables", 32'(rd_tag_en), 32'd0);
    check("R1 data enables", 32'(rd_data_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'(rsp_valid | mem_req), 32'd0);

    // first miss goes to bank 0 (R10), R5 all banks searched
    do_fetch(16'h0040, 1'b1, memw(16'h0040), 4'hF, 4'hF, "R5 R10 first");

    // R9 R10 table walk
    for (int i = 0; i < 14; i++)
      do_fetch(VEC[i][16:1], VEC[i][0], memw(VEC[i][16:1] & 16'hFFFC), 4'hF, 4'hF, "R9 R10 walk");

    // R12: bank 0 (holding line 0x4040) becomes scratchpad, then cache again
    do_cfg(4'b0001, 16'h4000, 16'h40FF);
    do_load(16'h4040, 32'hDEAD0001);
    do_fetch(16'h4040, 1'b0, 32'hDEAD0001, 4'h0, 4'b0001, "R3 R4 spm");
    do_fetch(16'h4140, 1'b1, memw(16'h4140), 4'b1110, 4'b1110, "R5 partial");
    do_cfg(4'b0000, 16'h0000, 16'h0000);
    do_fetch(16'h4040, 1'b1, memw(16'h4040), 4'hF, 4'hF, "R12 cleared");

    // R2 rejected writes leave mode and bounds unchanged
    do_cfg(4'b0011, 16'h8000, 16'h81FF);
    do_load(16'h8100, 32'hAAAA0001);
    do_cfg(4'b0001, 16'h8000, 16'h81FF);
    do_cfg(4'b0011, 16'h9000, 16'h8000);
    do_fetch(16'h8100, 1'b0, 32'hAAAA0001, 4'h0, 4'b0010, "R2 R4 reject");

    // R6 load outside the window is ignored
    do_load(16'h8104, 32'h11110006);
    do_cfg(4'b0011, 16'h8000, 16'h80FF);
    do_load(16'h8104, 32'h22220006);
    do_cfg(4'b0011, 16'h8000, 16'h81FF);
    do_fetch(16'h8104, 1'b0, 32'h11110006, 4'h0, 4'b0010, "R6 ignored load");
    do_fetch(16'h7FFC, 1'b1, memw(16'h7FFC), 4'b1100, 4'b1100, "R4 R5 below lo");

    // R4 ascending bank order and inclusive upper bound
    do_cfg(4'b1010, 16'h8000, 16'h81FF);
    do_load(16'h8004, 32'hA0000004);
    do_load(16'h81FC, 32'hB00001FC);
    do_fetch(16'h8004, 1'b0, 32'hA0000004, 4'h0, 4'b0010, "R4 slice0");
    do_fetch(16'h81FC, 1'b0, 32'hB00001FC, 4'h0, 4'b1000, "R4 slice1 hi");
    do_fetch(16'h8200, 1'b1, memw(16'h8200), 4'b0101, 4'b0101, "R4 R5 above hi");

    // R11 no cache banks: uncached, nothing allocated
    do_cfg(4'b1111, 16'hC000, 16'hC3FF);
    do_fetch(16'h1230, 1'b1, memw(16'h1230), 4'h0, 4'h0, "R11 uncached");
    do_fetch(16'h1230, 1'b1, memw(16'h1230), 4'h0, 4'h0, "R11 repeat");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule